// File: doc/BRIEF.md
# Incremental Converter Sequencer

This block holds the digital side of a first-order incremental (integrating) converter. It runs on a fast system clock and makes a slower data-clock enable with a selectable divide. It opens an integration window of 2^N data-clock periods and steers an external switched integrator through that window. On each data tick it tells the integrator whether to subtract the reference, based on the comparator, so the integrator stays near analog ground. It counts the ticks in which the comparator is high, and then adds one more data period in which the integrator is held in reset and the result is formed.

A free-running 16-bit trip counter is captured when a start is accepted. The result is that counter at the end of the window minus the captured value, clamped to the full-scale code 2^N-1. It is delivered either as a plain count or as a two's-complement value centred on mid-scale. A data-available flag can be polled, and a read strobe clears it. The resolution, divide, format and source select are taken in at the start and hold for the whole conversion.

Top module: `incadc_seq`

## Requirements
- R1: After reset, busy and data_valid are 0, int_rst is 1, ref_sub is 0, src_sel is 0 and result is 0.
- R2: res_sel picks the resolution N: 0 gives 8 bits, 1 gives 9 bits, and 2 or 3 give 10 bits. A conversion integrates for exactly 2^N data ticks, and busy is high from the accepted start until the result is posted.
- R3: The unsigned result is the number of window ticks in which comp_in was 1, clamped to 2^N-1. Comparator activity on ticks outside the window does not change it.
- R4: int_rst is low only during the window. One extra data tick follows the window with int_rst high, and data_valid rises with the result on that tick: (2^N+1)·D system clocks after the start edge, where D is the divide.
- R5: On each window tick except the last, ref_sub takes the value comp_in had at that tick (1 means subtract the reference). ref_sub is 0 outside the window.
- R6: div_sel picks the data-clock divide D: 0 gives 6, 1 gives 12, and 2 or 3 give 36 system clocks per data tick. The first tick comes D clocks after the start edge.
- R7: When signed_mode is 1, the result is the clamped count minus 2^(N-1), in 16-bit two's complement. When it is 0, the result is the count zero-extended.
- R8: A one-cycle rd pulse clears data_valid. result keeps its value until the next conversion ends.
- R9: src_sel outputs the src_in value captured at the accepted start (0 for the analog bus, 1 for the temperature sensor).
- R10: A start while busy is ignored. Changes to res_sel, div_sel, signed_mode or src_in during a conversion change neither its timing nor its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, taken when idle |
| res_sel | input | 2 | Resolution code |
| div_sel | input | 2 | Data-clock divide code |
| signed_mode | input | 1 | 1 = offset two's-complement result |
| src_in | input | 1 | Source choice, captured at start |
| comp_in | input | 1 | Comparator output of the integrator |
| rd | input | 1 | Result read strobe |
| int_rst | output | 1 | Integrator reset, high outside the window |
| ref_sub | output | 1 | 1 = subtract the reference this data period |
| src_sel | output | 1 | Captured source select |
| busy | output | 1 | Conversion in progress |
| data_valid | output | 1 | Result available |
| result | output | 16 | Conversion result |

## Verification
The assertions assume that start, rd and the configuration inputs are synchronous to clk. They also assume that comp_in has settled before each data tick, since ref_sub is checked against the comparator value sampled on that tick. The bench changes every input one nanosecond after a rising edge. It drives comp_in from a schedule it computes, or from a behavioural integrator that responds to ref_sub, and it leaves a start held high only for as long as a conversion is running.

// File: rtl/incadc_pkg.sv
package incadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_INTEG  = 2'd1,
    ST_FINISH = 2'd2
  } seq_state_e;

  // Resolution code to number of result bits.
  function automatic logic [3:0] res_bits(input logic [1:0] code);
    case (code)
      2'd0:    res_bits = 4'd8;
      2'd1:    res_bits = 4'd9;
      default: res_bits = 4'd10;
    endcase
  endfunction

endpackage

// File: rtl/incadc_clkdiv.sv
module incadc_clkdiv #(
  parameter int DIV0 = 6,
  parameter int DIV1 = 12,
  parameter int DIV2 = 36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int DMAX01 = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int DMAX   = (DMAX01 > DIV2) ? DMAX01 : DIV2;
  localparam int DIV_W  = (DMAX > 2) ? $clog2(DMAX) : 1;

  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (div_sel)
      2'd0:    lim = DIV_W'(DIV0 - 1);
      2'd1:    lim = DIV_W'(DIV1 - 1);
      default: lim = DIV_W'(DIV2 - 1);
    endcase
  end

  assign tick = (cnt_q == lim);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Phase counter stays inside the selected period.
  assert_div_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

endmodule

// File: rtl/incadc_win_timer.sv
module incadc_win_timer #(
  parameter int TMR_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step,
  input  logic [3:0] nbits,
  output logic       last
);
  logic [TMR_W-1:0] cnt_q, cnt_d, lim;

  assign lim  = TMR_W'((32'd1 << nbits) - 32'd1);
  assign last = step && (cnt_q == lim);

  always_comb begin
    if (clear || last) cnt_d = '0;
    else if (step)     cnt_d = cnt_q + 1'b1;
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Window position never runs past 2^N-1.
  assert_win_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

endmodule

// File: rtl/incadc_trip_cnt.sv
module incadc_trip_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = en ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_trip_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  assert_trip_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));

endmodule

// File: rtl/incadc_seq.sv
module incadc_seq
  import incadc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TMR_W    = 16,
  parameter int DIV_FAST = 6,
  parameter int DIV_MID  = 12,
  parameter int DIV_SLOW = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       res_sel,
  input  logic [1:0]       div_sel,
  input  logic             signed_mode,
  input  logic             src_in,
  input  logic             comp_in,
  input  logic             rd,
  output logic             int_rst,
  output logic             ref_sub,
  output logic             src_sel,
  output logic             busy,
  output logic             data_valid,
  output logic [CNT_W-1:0] result
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  seq_state_e       st_q, st_d;
  logic [1:0]       res_q, res_d, div_q, div_d;
  logic             sgn_q, sgn_d, src_q, src_d;
  logic             ref_q, ref_d, dv_q, dv_d;
  logic [CNT_W-1:0] snap_q, snap_d, res_val_q, res_val_d;

  logic             accept, tick, last, fin, win_step, cnt_en;
  logic [CNT_W-1:0] trip;
  logic [3:0]       nb;
  logic [CNT_W-1:0] fs_lim, half, diff, sat;

  assign accept   = (st_q == ST_IDLE) && start;
  assign win_step = (st_q == ST_INTEG) && tick;
  assign fin      = (st_q == ST_FINISH) && tick;
  // A tick on the accepting edge belongs to no window.
  assign cnt_en   = tick && comp_in && !accept;

  incadc_clkdiv #(
    .DIV0(DIV_FAST), .DIV1(DIV_MID), .DIV2(DIV_SLOW)
  ) u_div (
    .clk(clk), .rst_n(rst_int_n), .restart(accept),
    .div_sel(div_q), .tick(tick)
  );

  incadc_win_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_int_n), .clear(accept),
    .step(win_step), .nbits(nb), .last(last)
  );

  incadc_trip_cnt #(.CNT_W(CNT_W)) u_trip (
    .clk(clk), .rst_n(rst_int_n), .en(cnt_en), .cnt(trip)
  );

  // Result arithmetic.
  always_comb begin
    nb     = res_bits(res_q);
    fs_lim = CNT_W'((32'd1 << nb) - 32'd1);
    half   = CNT_W'(32'd1 << (nb - 4'd1));
    diff   = trip - snap_q;
    sat    = (diff > fs_lim) ? fs_lim : diff;
  end

  // Next-state logic.
  always_comb begin
    st_d      = st_q;
    res_d     = res_q;
    div_d     = div_q;
    sgn_d     = sgn_q;
    src_d     = src_q;
    snap_d    = snap_q;
    res_val_d = res_val_q;
    ref_d     = 1'b0;
    dv_d      = dv_q;

    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_INTEG;
          res_d  = res_sel;
          div_d  = div_sel;
          sgn_d  = signed_mode;
          src_d  = src_in;
          snap_d = trip;
        end
      end
      ST_INTEG: begin
        if (win_step && !last) ref_d = comp_in;
        else if (!win_step)    ref_d = ref_q;
        if (last) st_d = ST_FINISH;
      end
      ST_FINISH: begin
        if (tick) begin
          st_d      = ST_IDLE;
          res_val_d = sgn_q ? (sat - half) : sat;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (fin)     dv_d = 1'b1;
    else if (rd) dv_d = 1'b0;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q      <= ST_IDLE;
      res_q     <= 2'd0;
      div_q     <= 2'd0;
      sgn_q     <= 1'b0;
      src_q     <= 1'b0;
      snap_q    <= '0;
      res_val_q <= '0;
      ref_q     <= 1'b0;
      dv_q      <= 1'b0;
    end else begin
      st_q      <= st_d;
      res_q     <= res_d;
      div_q     <= div_d;
      sgn_q     <= sgn_d;
      src_q     <= src_d;
      snap_q    <= snap_d;
      res_val_q <= res_val_d;
      ref_q     <= ref_d;
      dv_q      <= dv_d;
    end
  end

  assign int_rst    = (st_q != ST_INTEG);
  assign ref_sub    = ref_q;
  assign src_sel    = src_q;
  assign busy       = (st_q != ST_IDLE);
  assign data_valid = dv_q;
  assign result     = res_val_q;

  assert_finish_quiet_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_FINISH) |-> (int_rst && !ref_sub));
  assert_post_result_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    fin |=> (data_valid && !busy));
  assert_ref_follow_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (win_step && !last) |=> (ref_sub == $past(comp_in)));
  assert_uns_range_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fin && !sgn_q) |=> (result <= $past(fs_lim)));
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd && !fin) |=> !data_valid);
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> ($stable(res_q) && $stable(div_q) && $stable(sgn_q) && $stable(src_q)));

endmodule

// File: tb/incadc_seq_tb.sv
module incadc_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic [1:0]  div_sel = 2'd0;
  logic        signed_mode = 1'b0;
  logic        src_in = 1'b0;
  logic        comp_in = 1'b0;
  logic        rd = 1'b0;
  logic        int_rst, ref_sub, src_sel, busy, data_valid;
  logic [15:0] result;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  incadc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .res_sel(res_sel),
    .div_sel(div_sel), .signed_mode(signed_mode), .src_in(src_in),
    .comp_in(comp_in), .rd(rd), .int_rst(int_rst), .ref_sub(ref_sub),
    .src_sel(src_sel), .busy(busy), .data_valid(data_valid), .result(result)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // One conversion; pat: 0 low, 1 high, 2 every third, 3 integrator model, 4 alternate.
  task automatic run(input int code, input int dsel, input bit sg, input bit src,
                     input int pat, input int vin, input bit disturb, output int cnt);
    int n, d, len, integ, err, fs, sat, expv;
    bit c;
    fs    = 1000;
    n     = 8 + ((code > 2) ? 2 : code);
    d     = (dsel == 0) ? 6 : (dsel == 1) ? 12 : 36;
    len   = 1 << n;
    integ = 0;
    cnt   = 0;
    err   = 0;
    @(negedge clk);
    res_sel = 2'(code); div_sel = 2'(dsel); signed_mode = sg; src_in = src;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(src_sel == src, "R9 src_sel captured", src_sel, src);
    chk(int_rst == 1'b0, "R4 int_rst low in window", int_rst, 0);
    for (int i = 0; i < len; i++) begin
      case (pat)
        0: c = 1'b0;
        1: c = 1'b1;
        2: c = (i % 3 == 0);
        3: c = (integ >= fs);
        default: c = i[0];
      endcase
      comp_in = c;
      if (c) cnt++;
      if (disturb && i == 5) begin
        start = 1'b1; res_sel = 2'd2; div_sel = 2'(dsel ^ 1); src_in = ~src;
        signed_mode = ~sg;
      end
      repeat (d) @(posedge clk);
      #1;
      if (disturb && i == 6) start = 1'b0;
      if (i < len - 1) begin
        if (ref_sub != c || int_rst != 1'b0) err++;
      end else begin
        if (ref_sub != 1'b0 || int_rst != 1'b1 || busy != 1'b1) err++;
      end
      if (pat == 3) integ = integ + vin - (c ? fs : 0);
    end
    chk(err == 0, "R5 ref_sub per tick", err, 0);
    repeat (d - 1) @(posedge clk);
    #1;
    chk(data_valid == 1'b0 && busy == 1'b1, "R4 R6 no result before extra tick",
        data_valid, 0);
    @(posedge clk); #1;
    chk(data_valid == 1'b1 && busy == 1'b0, "R4 R6 result on extra tick", data_valid, 1);
    sat  = (cnt > len - 1) ? len - 1 : cnt;
    expv = sg ? ((sat - len / 2) & 16'hFFFF) : sat;
    chk(int'(result) == expv, sg ? "R7 signed result" : "R3 count result",
        int'(result), expv);
    chk(src_sel == src, "R10 src_sel held", src_sel, src);
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1'b1;
    @(posedge clk); #1; rd = 1'b0;
    chk(data_valid == 1'b0, "R8 read clears flag", data_valid, 0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(data_valid == 1'b0, "R1 data_valid", data_valid, 0);
    chk(int_rst == 1'b1, "R1 int_rst", int_rst, 1);
    chk(ref_sub == 1'b0 && src_sel == 1'b0, "R1 ref_sub src_sel", ref_sub, 0);
    chk(result == 16'd0, "R1 result", result, 0);
  endtask

  task automatic t_full_scale();
    int c;
    run(0, 0, 1'b0, 1'b0, 1, 0, 1'b0, c);   // R3: 256 highs clamp to 255
    do_read();
  endtask

  task automatic t_zero_signed();
    int c;
    run(0, 0, 1'b1, 1'b1, 0, 0, 1'b0, c);   // R7: 0 - 128
    do_read();
  endtask

  task automatic t_nine_bit();
    int c;
    run(1, 0, 1'b0, 1'b0, 2, 0, 1'b0, c);   // R2 R3: 171 of 512
    do_read();
  endtask

  task automatic t_ten_bit_model();
    int c;
    run(3, 0, 1'b1, 1'b0, 3, 300, 1'b0, c); // R2 R5 R7 with feedback model
    do_read();
  endtask

  task automatic t_dividers();
    int c;
    run(0, 1, 1'b0, 1'b0, 4, 0, 1'b0, c);   // R6 divide 12
    do_read();
    run(0, 2, 1'b0, 1'b1, 4, 0, 1'b0, c);   // R6 divide 36
    do_read();
  endtask

  task automatic t_read_hold();
    int c;
    logic [15:0] kept;
    run(0, 0, 1'b0, 1'b0, 2, 0, 1'b0, c);
    kept = result;
    do_read();
    chk(result == kept, "R8 result held after read", result, kept);
    do_read();
    chk(result == kept, "R8 second read no change", result, kept);
  endtask

  task automatic t_busy_start();
    int c;
    run(0, 0, 1'b0, 1'b1, 2, 0, 1'b1, c);   // R10 mid-run start and setting changes
    do_read();
    repeat (20) @(posedge clk);
    #1;
    chk(busy == 1'b0, "R10 no conversion from ignored start", busy, 0);
  endtask

  task automatic t_idle_trips();
    int c;
    @(negedge clk); comp_in = 1'b1;
    repeat (100) @(posedge clk);
    run(0, 0, 1'b0, 1'b0, 0, 0, 1'b0, c);   // R3 idle trips excluded -> 0
    do_read();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_full_scale();
    t_zero_signed();
    t_nine_bit();
    t_ten_bit_model();
    t_dividers();
    t_read_hold();
    t_busy_start();
    t_idle_trips();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule